// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block is the digital half of an 8-bit successive-approximation converter that sits on a small microcontroller register bus. Software picks one of four analog inputs, sets a conversion rate through a prescaler and writes a start bit. The controller then holds the chosen channel on the sample-and-hold. It walks a trial code from the most significant bit down to the least, and drives that code onto a resistor-ladder DAC. For each bit it reads back a single comparator input.

When the last bit is settled, the finished code is latched into a result register and a done flag goes high. The done flag can optionally replace the external interrupt-1 pin as the source of the interrupt line. In that mode a completed conversion appears as a falling edge. The analog multiplexer, sample-and-hold, ladder and comparator stay outside and are seen only through ports.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Register map on a 2-bit address. Address 0 is control: bits [1:0] channel, bit 2 start, bit 3 done (read-only), bit 4 interrupt-route enable. Address 1 is the read-only result. Address 2 is the prescaler. Address 3 reads as zero. `bus_rdata` is registered and shows, one clock later, the register addressed on the previous clock.
- R2: The result is decided MSB first, one bit per step. A bit stays set when `cmp_in` is high on the step's final converter clock and is cleared when `cmp_in` is low, so with a comparator that reports input ≥ trial code, the result equals the input level.
- R3: `chan_sel` takes the channel field written together with the start bit and stays constant until the conversion ends; `sh_hold` is high exactly while converting.
- R4: A write with bit 2 set starts a conversion when idle. The start bit reads back as 1 for one cycle and then as 0.
- R5: The converter clock is the system clock divided by 2·(P+1), P being the prescaler. Each bit takes 8 converter clocks, so the done flag rises exactly 128·(P+1) clocks after the start write edge.
- R6: The done bit (control bit 3 and `conv_done`) clears on an accepted start, stays low during conversion and is set on the edge that loads the result.
- R7: The result register keeps its previous value during a conversion and changes only when the conversion completes.
- R8: A start write while busy is ignored: timing, channel and result of the running conversion are unaffected.
- R9: With the route enable set, `int1_line` is the inverted done flag, registered, so completion shows as a falling edge one clock after done rises.
- R10: With the route enable set, `int1_pin` has no effect on `int1_line`; with it clear, `int1_line` follows `int1_pin` one clock later.
- R11: Synchronous reset clears control, prescaler, result and done, stops any conversion and sets `int1_line` high.
- R12: `dac_code` is zero whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_in | input | 1 | Comparator: high when analog input ≥ trial code |
| int1_pin | input | 1 | External interrupt-1 pin level |
| chan_sel | output | 2 | Analog channel for the input multiplexer |
| sh_hold | output | 1 | Sample-and-hold in hold mode (converting) |
| dac_code | output | 8 | Trial code to the ladder DAC |
| conv_done | output | 1 | Conversion done flag |
| int1_line | output | 1 | Interrupt-1 line toward the interrupt controller |

## Verification
A wrong bit index or a mask error in the approximation shows as a result that differs from the input level. It is visible at the result read right after the done flag. A miscount in the prescaler or the per-bit step counter moves the done edge, and this is caught to the exact clock against 128·(P+1). A stale channel register, a start accepted while busy, or a premature result load shows during the conversion itself, at mid-conversion samples of `chan_sel` and the result register. A wrong route of the interrupt line shows one clock after done rises.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_RES  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 2'd2;
  localparam int CB_START = 2;
  localparam int CB_DONE  = 3;
  localparam int CB_IEN   = 4;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PSC_W  = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic [DATA_W-1:0] fin_code,
  output logic              start_go,
  output logic [CH_W-1:0]   conv_ch,
  output logic [PSC_W-1:0]  psc_q,
  output logic              int_en,
  output logic              done_q,
  output logic              start_q,
  output logic [DATA_W-1:0] res_q
);
  logic [CH_W-1:0]   chan_fld;
  logic [DATA_W-1:0] ctrl_view;
  logic              ctrl_wr;

  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign start_go = ctrl_wr && bus_wdata[CB_START] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_fld <= '0;
      conv_ch  <= '0;
      psc_q    <= '0;
      int_en   <= 1'b0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
      res_q    <= '0;
    end else begin
      start_q <= start_go;
      if (ctrl_wr) begin
        chan_fld <= bus_wdata[CH_W-1:0];
        int_en   <= bus_wdata[CB_IEN];
      end
      if (start_go) begin
        conv_ch <= bus_wdata[CH_W-1:0];
        done_q  <= 1'b0;
      end else if (fin) begin
        done_q <= 1'b1;
      end
      if (fin) res_q <= fin_code;
      if (bus_we && bus_addr == A_PSC) psc_q <= PSC_W'(bus_wdata);
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CH_W-1:0] = chan_fld;
    ctrl_view[CB_START] = start_q;
    ctrl_view[CB_DONE]  = done_q;
    ctrl_view[CB_IEN]   = int_en;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_RES:   bus_rdata <= res_q;
        A_PSC:   bus_rdata <= DATA_W'(psc_q);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic             half_q;
  logic [PSC_W-1:0] cnt_q;

  assign tick = run && half_q && (cnt_q == psc);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) begin
        if (cnt_q == psc) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int DATA_W    = 8,
  parameter int STEP_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              cmp_in,
  output logic              busy,
  output logic [DATA_W-1:0] code,
  output logic              fin,
  output logic [DATA_W-1:0] fin_code
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int SUB_W = $clog2(STEP_CLKS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(STEP_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [SUB_W-1:0]  sub_q;
  logic [DATA_W-1:0] cur_bit;
  logic [DATA_W-1:0] kept;
  logic              decide;

  assign cur_bit  = DATA_W'(1) << idx_q;
  assign kept     = cmp_in ? code : (code & ~cur_bit);
  assign decide   = busy && tick && (sub_q == SUB_LAST);
  assign fin      = decide && (idx_q == '0);
  assign fin_code = kept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      code  <= '0;
      idx_q <= '0;
      sub_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      code  <= DATA_W'(1) << IDX_TOP;
      idx_q <= IDX_TOP;
      sub_q <= '0;
    end else if (busy && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (idx_q == '0) begin
          busy <= 1'b0;
          code <= '0;
        end else begin
          code  <= kept | (DATA_W'(1) << (idx_q - 1'b1));
          idx_q <= idx_q - 1'b1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_irq_route.sv
module sar_irq_route (
  input  logic clk,
  input  logic rst,
  input  logic route_en,
  input  logic done,
  input  logic pin,
  output logic line
);
  always_ff @(posedge clk) begin
    if (rst)           line <= 1'b1;
    else if (route_en) line <= ~done;
    else               line <= pin;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int PSC_W     = 8,
  parameter int STEP_CLKS = 8,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_in,
  input  logic              int1_pin,
  output logic [CH_W-1:0]   chan_sel,
  output logic              sh_hold,
  output logic [DATA_W-1:0] dac_code,
  output logic              conv_done,
  output logic              int1_line
);
  logic              start_go, busy_w, tick_w, fin_w, int_en_w, start_bit_w;
  logic [DATA_W-1:0] fin_code_w, res_w;
  logic [PSC_W-1:0]  psc_w;

  sar_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CH_W(CH_W)) regs_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w),
    .fin(fin_w), .fin_code(fin_code_w), .start_go(start_go),
    .conv_ch(chan_sel), .psc_q(psc_w), .int_en(int_en_w),
    .done_q(conv_done), .start_q(start_bit_w), .res_q(res_w)
  );

  sar_clkdiv #(.PSC_W(PSC_W)) div_i (
    .clk(clk), .rst(rst), .run(busy_w), .psc(psc_w), .tick(tick_w)
  );

  sar_engine #(.DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)) eng_i (
    .clk(clk), .rst(rst), .start(start_go), .tick(tick_w), .cmp_in(cmp_in),
    .busy(busy_w), .code(dac_code), .fin(fin_w), .fin_code(fin_code_w)
  );

  sar_irq_route irq_i (
    .clk(clk), .rst(rst), .route_en(int_en_w), .done(conv_done),
    .pin(int1_pin), .line(int1_line)
  );

  assign sh_hold = busy_w;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              start_bit,
  input logic              int_en,
  input logic              int1_line,
  input logic [DATA_W-1:0] dac_code,
  input logic [CH_W-1:0]   chan_sel,
  input logic [DATA_W-1:0] res
);
  // R6
  done_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R4
  start_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_bit |=> !start_bit);
  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(res));
  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(chan_sel));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (int_en && $rose(done)) |=> (!int_en || !int1_line));
  // R12
  idle_dac_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy_w), .done(conv_done),
  .start_bit(start_bit_w), .int_en(int_en_w), .int1_line(int1_line),
  .dac_code(dac_code), .chan_sel(chan_sel), .res(res_w)
);

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cmp_in;
  logic       int1_pin = 1'b1;
  logic [1:0] chan_sel;
  logic       sh_hold;
  logic [7:0] dac_code;
  logic       conv_done;
  logic       int1_line;

  logic [7:0] vin [4];
  logic [7:0] last_res = 8'd0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= dac_code);

  sar_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .int1_pin(int1_pin), .chan_sel(chan_sel), .sh_hold(sh_hold),
    .dac_code(dac_code), .conv_done(conv_done), .int1_line(int1_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  function automatic int exp_cycles(input int p);
    return 128 * (p + 1) + 1;
  endfunction

  task automatic run_conv(input int ch, input int p, input bit en, input bit inject);
    int cnt;
    bit seen;
    logic [7:0] rv;
    logic [7:0] expv;
    logic [7:0] prev;
    expv = vin[ch];
    prev = last_res;
    bus_write(2'd2, 8'(p));
    @(negedge clk);
    bus_addr = 2'd0;
    bus_wdata = {3'b000, en, 1'b0, 1'b1, 2'(ch)};
    bus_we = 1'b1;
    cnt = 0; seen = 0;
    while (!seen && cnt < 40000) begin
      @(posedge clk); cnt++; #1;
      if (cnt == 1) bus_we = 1'b0;
      if (cnt == 2) chk(bus_rdata[2] == 1'b1, "R4 start bit set", int'(bus_rdata[2]), 1);
      if (cnt == 3) begin
        chk(bus_rdata[2] == 1'b0, "R4 start bit self-clear", int'(bus_rdata[2]), 0);
        chk(bus_rdata[3] == 1'b0, "R6 done low while busy", int'(bus_rdata[3]), 0);
      end
      if (inject && cnt == 20) begin
        bus_wdata = {3'b000, en, 1'b0, 1'b1, 2'(ch + 1)};
        bus_we = 1'b1;
      end
      if (cnt == 21) bus_we = 1'b0;
      if (cnt == 24) bus_addr = 2'd1;
      if (cnt == 40) begin
        chk(bus_rdata == prev, "R7 result held mid-conversion", int'(bus_rdata), int'(prev));
        chk(chan_sel == 2'(ch), "R3 R8 channel held", int'(chan_sel), ch);
        chk(sh_hold == 1'b1, "R3 hold while converting", int'(sh_hold), 1);
        chk(conv_done == 1'b0, "R6 done low", int'(conv_done), 0);
      end
      seen = conv_done;
    end
    chk(cnt == exp_cycles(p), "R5 R8 conversion time", cnt, exp_cycles(p));
    @(posedge clk); #1;
    chk(int1_line == (en ? 1'b0 : int1_pin), "R9 interrupt line after done",
        int'(int1_line), en ? 0 : int'(int1_pin));
    chk(dac_code == 8'd0, "R12 idle dac code", int'(dac_code), 0);
    bus_read(2'd1, rv);
    chk(rv == expv, "R2 result value", int'(rv), int'(expv));
    bus_read(2'd0, rv);
    chk(rv[3] == 1'b1, "R6 done bit set", int'(rv[3]), 1);
    last_res = expv;
  endtask

  initial begin
    logic [7:0] rv;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4; i++) vin[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(conv_done == 1'b0, "R11 reset done", int'(conv_done), 0);
    chk(dac_code == 8'd0, "R11 R12 reset dac", int'(dac_code), 0);
    chk(sh_hold == 1'b0, "R11 reset idle", int'(sh_hold), 0);
    bus_read(2'd0, rv); chk(rv == 8'd0, "R1 R11 control reset", int'(rv), 0);
    bus_read(2'd1, rv); chk(rv == 8'd0, "R1 R11 result reset", int'(rv), 0);
    bus_read(2'd2, rv); chk(rv == 8'd0, "R1 R11 prescaler reset", int'(rv), 0);
    bus_write(2'd2, 8'hA5);
    bus_read(2'd2, rv); chk(rv == 8'hA5, "R1 prescaler readback", int'(rv), 8'hA5);
    bus_read(2'd3, rv); chk(rv == 8'd0, "R1 unused address", int'(rv), 0);

    // directed corners
    vin[0] = 8'd0;   run_conv(0, 0, 1'b0, 1'b0);
    vin[1] = 8'd255; run_conv(1, 0, 1'b1, 1'b0);
    vin[2] = 8'h80;  run_conv(2, 1, 1'b0, 1'b1);
    vin[3] = 8'h7F;  run_conv(3, 2, 1'b1, 1'b1);
    vin[0] = 8'h55;  run_conv(0, 255, 1'b0, 1'b0);

    // R10: route enabled, pin ignored
    bus_write(2'd0, 8'h10);
    repeat (2) @(posedge clk);
    int1_pin = 1'b0; @(posedge clk); #1;
    chk(int1_line == 1'b0, "R10 pin ignored (done set)", int'(int1_line), 0);
    int1_pin = 1'b1; @(posedge clk); #1; @(posedge clk); #1;
    chk(int1_line == 1'b0, "R10 pin ignored high", int'(int1_line), 0);
    // R10: route disabled, pin passes through
    bus_write(2'd0, 8'h00);
    int1_pin = 1'b0; @(posedge clk); #1; @(posedge clk); #1;
    chk(int1_line == 1'b0, "R10 pin follows low", int'(int1_line), 0);
    int1_pin = 1'b1; @(posedge clk); #1;
    chk(int1_line == 1'b1, "R10 pin follows high", int'(int1_line), 1);

    // constrained random conversions
    for (int k = 0; k < 24; k++) begin
      int ch;
      ch = int'($urandom % 4);
      vin[ch] = 8'($urandom);
      run_conv(ch, int'($urandom % 3), 1'($urandom), 1'($urandom));
    end

    // R11: reset during a conversion
    bus_write(2'd2, 8'd1);
    bus_write(2'd0, 8'h16);
    repeat (50) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk(sh_hold == 1'b0, "R11 conversion stopped", int'(sh_hold), 0);
    chk(conv_done == 1'b0, "R11 done cleared", int'(conv_done), 0);
    chk(dac_code == 8'd0, "R11 dac cleared", int'(dac_code), 0);
    chk(int1_line == 1'b1, "R11 line high", int'(int1_line), 1);
    bus_read(2'd1, rv); chk(rv == 8'd0, "R11 result cleared", int'(rv), 0);
    bus_read(2'd0, rv); chk(rv == 8'd0, "R11 control cleared", int'(rv), 0);
    bus_read(2'd2, rv); chk(rv == 8'd0, "R11 prescaler cleared", int'(rv), 0);

    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule